// File: doc/BRIEF.md
# Receive Front-End Source Selector with DC Removal

This block sits between two ADC sample streams and the I/Q inputs of a downconverter. Each of the two output paths, I and Q, picks its sample from ADC A, from ADC B, or from a constant zero. A 4-bit routing word held in a configuration register sets the choice. After selection, each path removes a DC offset. The offset is either a fixed signed value written by software or an estimate from an automatic tracking loop. The result is clamped to the sample width.

Configuration arrives as single-cycle writes on a simple settings bus: a strobe, an address and a 32-bit data word. There are three registers: the routing word at address 0, the I-path offset control at address 1 and the Q-path offset control at address 2. Both paths accept a new sample on every clock.

In automatic mode a signed accumulator integrates the path output. The accumulator shifted right by K bits is the offset estimate. The loop behaves as a first-order high-pass with a corner near fs / (2π·2^K).

Top module: `rxfe_dc_top`

## Requirements
- R1: Routing word (address 0): bits [1:0] choose the I source and bits [3:2] choose the Q source; code 00 selects ADC A and code 01 selects ADC B.
- R2: A source code with its upper bit set (10 or 11) makes that path output exactly zero, whatever its offset mode.
- R3: After reset the routing word is 0x4 (I from A, Q from B), both paths are in automatic mode with a zero estimate, and both outputs are zero.
- R4: An offset register (address 1 for I, address 2 for Q) with bit 31 set selects fixed mode. The output is the selected sample minus bits [13:0] read as a signed 14-bit value. Bits [30:14] have no effect.
- R5: The subtraction result saturates to the signed sample range [-8192, 8191] and never wraps.
- R6: With bit 31 clear the path is in automatic mode: the estimate is the accumulator shifted right arithmetically by K, and each output is added into the accumulator. For a constant input the output settles to within ±1 LSB of zero.
- R7: A write to a path's offset register clears that path's accumulator on the write edge. The other path's accumulator is not affected.
- R8: A sample presented before a clock edge appears at the output after the second edge (two register stages).
- R9: In automatic mode, for an input made of a constant plus a slow ramp (1 LSB per 256 samples), the output mean over 1024 settled samples is within ±4 LSB of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_stb | input | 1 | Settings write strobe, one cycle per write |
| cfg_addr | input | 8 | Settings register address |
| cfg_data | input | 32 | Settings write data |
| adc_a | input | 14 | Signed sample from ADC A |
| adc_b | input | 14 | Signed sample from ADC B |
| i_out | output | 14 | Signed I-path sample to the downconverter |
| q_out | output | 14 | Signed Q-path sample to the downconverter |

## Verification
The bound checker checks the following on every clock:
- The routing codes 00 and 01 carry the right ADC sample into the selection stage.
- A zero-coded path gives exactly zero at the output one cycle later.
- A fixed zero offset passes the selected sample through unchanged.
- The reset state is as required when reset is released.

Some behaviour is only visible over many samples, so only the bench scenarios can show it:
- convergence of the automatic loop to zero;
- the output mean under a ramp;
- clipping at both rails;
- the accumulator clear on a register write;
- the effect of the ignored offset bits.

// File: rtl/rxfe_dc_pkg.sv
package rxfe_dc_pkg;
  localparam int NPATH    = 2;
  localparam int SEL_W    = 2;
  localparam int OFS_W    = 14;
  localparam int MODE_BIT = 31;

  typedef struct packed {
    logic                    fixed_mode;
    logic signed [OFS_W-1:0] value;
  } ofs_cfg_t;

  function automatic logic code_is_zero(input logic [SEL_W-1:0] code);
    return code[SEL_W-1];
  endfunction
endpackage

// File: rtl/rxfe_cfg_regs.sv
module rxfe_cfg_regs
  import rxfe_dc_pkg::*;
#(
  parameter int            AW        = 8,
  parameter int            DW        = 32,
  parameter logic [AW-1:0] ADR_MUX   = 'd0,
  parameter logic [AW-1:0] ADR_OFS_I = 'd1,
  parameter logic [AW-1:0] ADR_OFS_Q = 'd2,
  parameter logic [NPATH*SEL_W-1:0] MUX_RST = 'h4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_stb,
  input  logic [AW-1:0]             cfg_addr,
  input  logic [DW-1:0]             cfg_data,
  output logic [NPATH*SEL_W-1:0]    mux_cfg,
  output ofs_cfg_t [NPATH-1:0]      ofs_cfg,
  output logic [NPATH-1:0]          acc_clr
);
  localparam int MW = NPATH*SEL_W;

  logic [MW-1:0]         mux_d;
  ofs_cfg_t [NPATH-1:0]  ofs_d;
  logic                  wr_mux;
  logic [NPATH-1:0]      wr_ofs;
  ofs_cfg_t              wr_word;

  always_comb begin
    wr_mux    = cfg_stb && (cfg_addr == ADR_MUX);
    wr_ofs[0] = cfg_stb && (cfg_addr == ADR_OFS_I);
    wr_ofs[1] = cfg_stb && (cfg_addr == ADR_OFS_Q);
    wr_word.fixed_mode = cfg_data[MODE_BIT];
    wr_word.value      = cfg_data[OFS_W-1:0];
  end

  always_comb begin
    mux_d = mux_cfg;
    if (wr_mux) mux_d = cfg_data[MW-1:0];
    for (int p = 0; p < NPATH; p++) begin
      ofs_d[p] = ofs_cfg[p];
      if (wr_ofs[p]) ofs_d[p] = wr_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mux_cfg <= MUX_RST;
      ofs_cfg <= '0;
    end else begin
      mux_cfg <= mux_d;
      ofs_cfg <= ofs_d;
    end
  end

  assign acc_clr = wr_ofs;
endmodule

// File: rtl/rxfe_src_sel.sv
module rxfe_src_sel
  import rxfe_dc_pkg::*;
#(
  parameter int W = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic signed [W-1:0] adc_a,
  input  logic signed [W-1:0] adc_b,
  input  logic [SEL_W-1:0]    code,
  output logic signed [W-1:0] smp,
  output logic                zero
);
  logic signed [W-1:0] smp_d;
  logic                zero_d;

  always_comb begin
    zero_d = code_is_zero(code);
    if (zero_d)       smp_d = '0;
    else if (code[0]) smp_d = adc_b;
    else              smp_d = adc_a;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp  <= '0;
      zero <= 1'b1;
    end else begin
      smp  <= smp_d;
      zero <= zero_d;
    end
  end
endmodule

// File: rtl/rxfe_dc_path.sv
module rxfe_dc_path
  import rxfe_dc_pkg::*;
#(
  parameter int W = 14,
  parameter int K = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic signed [W-1:0] x,
  input  logic                zero,
  input  ofs_cfg_t            ofs,
  input  logic                clr,
  output logic signed [W-1:0] y
);
  localparam int ACC_W = W + K + 2;
  localparam int EST_W = ACC_W - K;
  localparam int DIF_W = EST_W + 1;
  localparam int MAXI  = (2**(W-1)) - 1;
  localparam int MINI  = -(2**(W-1));
  localparam logic signed [DIF_W-1:0] MAXV = DIF_W'(MAXI);
  localparam logic signed [DIF_W-1:0] MINV = DIF_W'(MINI);

  logic signed [ACC_W-1:0] acc, acc_d;
  logic signed [EST_W-1:0] est;
  logic signed [DIF_W-1:0] diff;
  logic signed [W-1:0]     sat, y_d;
  logic                    acc_en;

  always_comb begin
    if (ofs.fixed_mode) est = EST_W'(ofs.value);
    else                est = EST_W'(acc >>> K);
    diff = DIF_W'(x) - DIF_W'(est);
    if (diff > MAXV)      sat = MAXV[W-1:0];
    else if (diff < MINV) sat = MINV[W-1:0];
    else                  sat = diff[W-1:0];
    y_d    = zero ? '0 : sat;
    acc_en = clr || (!zero && !ofs.fixed_mode);
    acc_d  = clr ? '0 : acc + ACC_W'(y_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) y <= '0;
    else        y <= y_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc <= '0;
    else if (acc_en) acc <= acc_d;
  end
endmodule

// File: rtl/rxfe_dc_top.sv
module rxfe_dc_top
  import rxfe_dc_pkg::*;
#(
  parameter int W  = 14,
  parameter int K  = 6,
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_stb,
  input  logic [AW-1:0]       cfg_addr,
  input  logic [DW-1:0]       cfg_data,
  input  logic signed [W-1:0] adc_a,
  input  logic signed [W-1:0] adc_b,
  output logic signed [W-1:0] i_out,
  output logic signed [W-1:0] q_out
);
  logic [NPATH*SEL_W-1:0]       mux_cfg;
  ofs_cfg_t [NPATH-1:0]         ofs_cfg;
  logic [NPATH-1:0]             acc_clr;
  logic [NPATH-1:0][W-1:0]      smp_s1;
  logic [NPATH-1:0]             zero_s1;
  logic [NPATH-1:0][W-1:0]      y_out;

  rxfe_cfg_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_stb(cfg_stb), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .mux_cfg(mux_cfg), .ofs_cfg(ofs_cfg), .acc_clr(acc_clr)
  );

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    logic signed [W-1:0] smp_p, y_p;

    rxfe_src_sel #(.W(W)) u_sel (
      .clk(clk), .rst_n(rst_n), .adc_a(adc_a), .adc_b(adc_b),
      .code(mux_cfg[p*SEL_W +: SEL_W]), .smp(smp_p), .zero(zero_s1[p])
    );

    rxfe_dc_path #(.W(W), .K(K)) u_dc (
      .clk(clk), .rst_n(rst_n), .x(smp_p), .zero(zero_s1[p]),
      .ofs(ofs_cfg[p]), .clr(acc_clr[p]), .y(y_p)
    );

    assign smp_s1[p] = smp_p;
    assign y_out[p]  = y_p;
  end

  assign i_out = y_out[0];
  assign q_out = y_out[1];
endmodule

// File: rtl/rxfe_dc_checker.sv
module rxfe_dc_checker
  import rxfe_dc_pkg::*;
#(
  parameter int W = 14
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [W-1:0]           adc_a,
  input logic [W-1:0]           adc_b,
  input logic [NPATH*SEL_W-1:0] mux_cfg,
  input ofs_cfg_t [NPATH-1:0]   ofs_cfg,
  input logic [NPATH-1:0][W-1:0] smp_s1,
  input logic [NPATH-1:0]       zero_s1,
  input logic [W-1:0]           i_out,
  input logic [W-1:0]           q_out
);
  a_r1_i_from_a: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_cfg[1:0] == 2'b00) |=> (smp_s1[0] == $past(adc_a)));

  a_r1_q_from_b: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_cfg[3:2] == 2'b01) |=> (smp_s1[1] == $past(adc_b)));

  a_r2_i_zero: assert property (@(posedge clk) disable iff (!rst_n)
    zero_s1[0] |=> (i_out == '0));

  a_r2_q_zero: assert property (@(posedge clk) disable iff (!rst_n)
    zero_s1[1] |=> (q_out == '0));

  a_r4_fixed_zero_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (ofs_cfg[0].fixed_mode && ofs_cfg[0].value == '0 && !zero_s1[0])
      |=> (i_out == $past(smp_s1[0])));

  a_r3_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (mux_cfg == 4'h4 && i_out == '0 && q_out == '0));
endmodule

bind rxfe_dc_top rxfe_dc_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .adc_a(adc_a), .adc_b(adc_b),
  .mux_cfg(mux_cfg), .ofs_cfg(ofs_cfg), .smp_s1(smp_s1),
  .zero_s1(zero_s1), .i_out(i_out), .q_out(q_out)
);

// File: tb/rxfe_dc_top_bench.sv
`timescale 1ns/1ps
module rxfe_dc_top_bench;
  localparam int W = 14;

  typedef struct packed {
    logic [3:0]          mux;
    logic [31:0]         ofi;
    logic [31:0]         ofq;
    logic signed [W-1:0] a;
    logic signed [W-1:0] b;
    logic signed [W-1:0] ei;
    logic signed [W-1:0] eq;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{4'h4, 32'h8000_0000, 32'h8000_0000,  14'sd100,  -14'sd200,  14'sd100, -14'sd200}, // R1
    '{4'h1, 32'h8000_0000, 32'h8000_0000,  14'sd300,  -14'sd50,  -14'sd50,   14'sd300}, // R1 swap
    '{4'h0, 32'h8000_0000, 32'h8000_0000,  14'sd7,     14'sd9,    14'sd7,    14'sd7},   // R1 both A
    '{4'h4, 32'h8000_000A, 32'h8000_3FEC,  14'sd50,    14'sd50,   14'sd40,   14'sd70},  // R4
    '{4'h4, 32'h8000_2000, 32'h8000_1FFF,  14'sd8191, -14'sd8192, 14'sd8191,-14'sd8192}, // R5
    '{4'hE, 32'h8000_0005, 32'h8000_0005,  14'sd123,   14'sd45,   14'sd0,    14'sd0},   // R2
    '{4'h5, 32'h8000_3FFF, 32'h8000_0000,  14'sd0,    -14'sd3,   -14'sd2,   -14'sd3},   // R1 both B, R4
    '{4'h4, 32'h8F00_0003, 32'h8000_0000,  14'sd10,    14'sd10,   14'sd7,    14'sd10}   // R4 ignored bits
  };

  logic                clk;
  logic                rst_n;
  logic                cfg_stb;
  logic [7:0]          cfg_addr;
  logic [31:0]         cfg_data;
  logic signed [W-1:0] adc_a, adc_b;
  logic signed [W-1:0] i_out, q_out;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  rxfe_dc_top u_rxfe_dc_top (
    .clk(clk), .rst_n(rst_n), .cfg_stb(cfg_stb), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .adc_a(adc_a), .adc_b(adc_b),
    .i_out(i_out), .q_out(q_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_near(input string req, input int act, input int tol);
    checks++;
    if (act > tol || act < -tol) begin
      failures++;
      $display("FAIL %s actual=%0d expected=0+/-%0d", req, act, tol);
    end
  endtask

  task automatic wr(input logic [7:0] adr, input logic [31:0] dat);
    cfg_stb = 1'b1; cfg_addr = adr; cfg_data = dat;
    @(negedge clk);
    cfg_stb = 1'b0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_stb = 1'b0; cfg_addr = '0; cfg_data = '0;
    adc_a = '0; adc_b = '0;
    repeat (3) @(negedge clk);
    chk("R3 i reset", i_out, 0);
    chk("R3 q reset", q_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 default routing, automatic with zero estimate: first output is the raw sample
    adc_a = 14'sd500; adc_b = -14'sd300;
    repeat (2) @(negedge clk);
    chk("R3 default I from A", i_out, 500);
    chk("R3 default Q from B", q_out, -300);

    // table walk, all fixed mode
    for (int n = 0; n < NV; n++) begin
      wr(8'd0, {28'd0, VECS[n].mux});
      wr(8'd1, VECS[n].ofi);
      wr(8'd2, VECS[n].ofq);
      adc_a = VECS[n].a; adc_b = VECS[n].b;
      repeat (3) @(negedge clk);
      chk($sformatf("R1/R2/R4/R5 vec%0d i", n), i_out, VECS[n].ei);
      chk($sformatf("R1/R2/R4/R5 vec%0d q", n), q_out, VECS[n].eq);
    end

    // R8 latency
    wr(8'd0, 32'h4); wr(8'd1, 32'h8000_0000); wr(8'd2, 32'h8000_0000);
    adc_a = '0; repeat (3) @(negedge clk);
    adc_a = 14'sd777;
    @(negedge clk);
    chk("R8 one edge still old", i_out, 0);
    @(negedge clk);
    chk("R8 two edges new", i_out, 777);

    // R6 automatic convergence
    wr(8'd1, 32'h0); wr(8'd2, 32'h0);
    adc_a = 14'sd1500; adc_b = -14'sd2200;
    repeat (3000) @(negedge clk);
    chk_near("R6 auto I settles", i_out, 1);
    chk_near("R6 auto Q settles", q_out, 1);

    // R7 clear on write, I only
    wr(8'd1, 32'h0);
    @(negedge clk);
    chk("R7 I accumulator cleared", i_out, 1500);
    chk_near("R7 Q untouched", q_out, 1);

    // R2 zero path in automatic mode
    wr(8'd0, 32'hA);
    repeat (3) @(negedge clk);
    chk("R2 auto zero I", i_out, 0);
    chk("R2 auto zero Q", q_out, 0);

    // R9 constant plus ramp
    wr(8'd0, 32'h4); wr(8'd1, 32'h0);
    begin
      int sum = 0;
      for (int t = 0; t < 4096; t++) begin
        adc_a = 14'(1000 + (t >> 8));
        @(negedge clk);
        if (t >= 3072) sum += int'(i_out);
      end
      checks++;
      if (sum > 4096 || sum < -4096) begin
        failures++;
        $display("FAIL R9 ramp mean sum actual=%0d expected=within +/-4096", sum);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule